// File: doc/BRIEF.md
# Bit-Synchronous Serial Host Controller

This block is the host side of a serial link to a radio coprocessor in which the device, not the host, drives the serial clock. The host paces the link with two outputs, a message-ready level and an active-low ready strobe. It watches the device's active-low enable line and takes in data bits on the edges of the device's clock. After power-up the controller waits a fixed time. It then runs a timed three-phase reset handshake on its two outputs. Next it waits for the enable line to go high and then fall. Only that falling edge allows the first ready strobe.

Every byte costs one ready strobe: a low pulse of fixed length followed by a return high. The device answers with eight clock edges. The first byte of each exchange is a sync byte, and the block sorts it into one of three kinds: the device has a message, the host may send, or unknown. The host logic asks for a transmit exchange with `tx_req`. The controller then raises message-ready and waits for the enable line to be low before it strobes. The host logic asks for each further byte with `next_byte` and closes the exchange with `end_xfer`. If the clock stops, a gap timer ends the exchange.

All durations are given in microseconds or nanoseconds. They are turned into cycle counts from the system clock frequency parameter.

Top module: `bsh_host_ctrl`

## Requirements
- R1: During reset and for PWRUP_US·CLK_KHZ/1000 cycles after it, msg_rdy=0, srdy_n=1, link_up=0, rx_valid=0 and timeout=0.
- R2: Reset phase one follows: msg_rdy=1 and srdy_n=1 for PH1_US·CLK_KHZ/1000 cycles.
- R3: Reset phase two follows: msg_rdy=1 and srdy_n=0 for PH2_US·CLK_KHZ/1000 cycles.
- R4: Reset phase three follows: msg_rdy=0 and srdy_n=0 for PH3_US·CLK_KHZ/1000 cycles. After that srdy_n returns to 1 with msg_rdy at 0.
- R5: After the handshake, no strobe is issued until sen_n has been seen high and then falls. A rise alone, or sen_n held low, gives no strobe. The first strobe sets link_up to 1.
- R6: Each ready strobe holds srdy_n low for exactly ceil(CLK_KHZ·STROBE_NS/1e6) cycles (at least 1) and then returns it high.
- R7: After a strobe, eight rising edges of sclk capture sin least significant bit first. Then rx_valid pulses high for exactly one cycle, with the byte on rx_byte.
- R8: The first byte after an exchange opens has rx_is_sync=1. sync_kind is 01 for SYNC_DEV (default A5h), 10 for SYNC_HOST (default A4h) and 11 for any other value. Later bytes have rx_is_sync=0 and sync_kind=00.
- R9: After a byte, a one-cycle `next_byte` issues a new strobe and leaves msg_rdy unchanged. `end_xfer` returns to idle with msg_rdy=0. If both are high in the same cycle, `end_xfer` wins and no strobe follows.
- R10: `tx_req` in idle raises msg_rdy before any strobe. The strobe waits until sen_n is low. msg_rdy stays 1 until the exchange ends.
- R11: In idle without `tx_req`, a falling edge of sen_n opens a receive exchange with a strobe while msg_rdy stays 0.
- R12: If no rising sclk edge comes within TIMEOUT_CYC cycles of the end of a strobe or of the previous edge, timeout pulses for one cycle, no byte is delivered, and the block returns to idle with msg_rdy=0.
- R13: sclk edges outside an exchange are ignored: no rx_valid, and the next exchange still receives its byte correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Host asks to open a transmit exchange |
| next_byte | input | 1 | Request one more byte in the current exchange |
| end_xfer | input | 1 | Close the current exchange |
| sen_n | input | 1 | Device enable line, active low, asynchronous |
| sclk | input | 1 | Device-driven serial clock, asynchronous |
| sin | input | 1 | Serial data from the device |
| msg_rdy | output | 1 | Message-ready line to the device |
| srdy_n | output | 1 | Ready strobe to the device, active low |
| link_up | output | 1 | Reset handshake complete and first strobe issued |
| rx_byte | output | 8 | Received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle pulse when a byte is complete |
| rx_is_sync | output | 1 | The delivered byte is the first of its exchange |
| sync_kind | output | 2 | Sync byte class: 00 none, 01 device message, 10 host may send, 11 unknown |
| timeout | output | 1 | One-cycle pulse when the clock gap limit expires |

## Verification
Some properties hold on every cycle, and the assertions check those. The exact strobe length is one. The phase order into the enable wait is another. A strobe may follow the enable-wait state only after a falling edge of enable, and a transmit strobe only with message-ready high and enable low. rx_valid never lasts two cycles, and a timeout always leaves the block idle. Other behaviour shows only in the bench's scenarios. This covers the length of each reset phase and the bit order and value of received bytes. It also covers the classification of sync bytes, the priority of closing over continuing, the fact that stray clocks are ignored, and when the gap timer fires.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

   typedef enum logic [3:0] {
      ST_PWRUP,
      ST_RST1,
      ST_RST2,
      ST_RST3,
      ST_EN_HI,
      ST_EN_FALL,
      ST_IDLE,
      ST_TX_ARM,
      ST_STROBE,
      ST_SHIFT,
      ST_HOLD
   } bsh_state_e;

   typedef enum logic [1:0] {
      SK_NONE     = 2'b00,
      SK_DEV_MSG  = 2'b01,
      SK_HOST_GO  = 2'b10,
      SK_UNKNOWN  = 2'b11
   } bsh_sync_kind_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // microseconds to cycles, never below one
   function automatic int unsigned us_to_cyc(input int unsigned khz, input int unsigned us);
      return max2(1, (khz * us) / 1000);
   endfunction

   // nanoseconds to cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned khz, input int unsigned ns);
      return max2(1, (khz * ns + 999_999) / 1_000_000);
   endfunction

endpackage

// File: rtl/bsh_insync.sv
module bsh_insync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bsh_insync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bsh_insync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], din};
   end

   assign lvl = stg[STAGES-1];

endmodule

// File: rtl/bsh_timer.sv
module bsh_timer #(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   if (W < 1) begin : g_bad_width
      $error("bsh_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= RST_VAL;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/bsh_shift.sv
module bsh_shift #(
   parameter int W         = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] data,
   output logic         last
);

   if (W < 2) begin : g_bad_width
      $error("bsh_shift: W must be at least 2");
   end

   localparam int CW = $clog2(W);

   logic [W-1:0]  sr;
   logic [W-1:0]  nxt;
   logic [CW-1:0] cnt;

   if (LSB_FIRST) begin : g_lsb
      assign nxt = {din, sr[W-1:1]};
   end else begin : g_msb
      assign nxt = {sr[W-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (clr) begin
         sr  <= '0;
         cnt <= '0;
      end else if (en) begin
         sr  <= nxt;
         cnt <= last ? '0 : cnt + 1'b1;
      end
   end

   assign data = sr;
   assign last = (cnt == CW'(W - 1));

   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (en && last) |=> (cnt == '0));

endmodule

// File: rtl/bsh_host_ctrl.sv
module bsh_host_ctrl
   import bsh_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 250_000,
   parameter int unsigned PWRUP_US    = 1000,
   parameter int unsigned PH1_US      = 1000,
   parameter int unsigned PH2_US      = 300,
   parameter int unsigned PH3_US      = 1000,
   parameter int unsigned STROBE_NS   = 3000,
   parameter int unsigned TIMEOUT_CYC = 100_000,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  SYNC_DEV    = 8'hA5,
   parameter logic [7:0]  SYNC_HOST   = 8'hA4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_req,
   input  logic       next_byte,
   input  logic       end_xfer,
   input  logic       sen_n,
   input  logic       sclk,
   input  logic       sin,
   output logic       msg_rdy,
   output logic       srdy_n,
   output logic       link_up,
   output logic [7:0] rx_byte,
   output logic       rx_valid,
   output logic       rx_is_sync,
   output logic [1:0] sync_kind,
   output logic       timeout
);

   localparam int unsigned PWRUP_C  = us_to_cyc(CLK_KHZ, PWRUP_US);
   localparam int unsigned PH1_C    = us_to_cyc(CLK_KHZ, PH1_US);
   localparam int unsigned PH2_C    = us_to_cyc(CLK_KHZ, PH2_US);
   localparam int unsigned PH3_C    = us_to_cyc(CLK_KHZ, PH3_US);
   localparam int unsigned STROBE_C = ns_to_cyc(CLK_KHZ, STROBE_NS);
   localparam int unsigned TO_C     = max2(1, TIMEOUT_CYC);
   localparam int unsigned MAX_C    = max2(max2(max2(PWRUP_C, PH1_C), max2(PH2_C, PH3_C)),
                                           max2(STROBE_C, TO_C));
   localparam int          TW       = $clog2(MAX_C + 1);

   if (CLK_KHZ == 0) begin : g_bad_clk
      $error("bsh_host_ctrl: CLK_KHZ must be nonzero");
   end
   if (TIMEOUT_CYC == 0) begin : g_bad_timeout
      $error("bsh_host_ctrl: TIMEOUT_CYC must be nonzero");
   end
   if (SYNC_DEV == SYNC_HOST) begin : g_bad_sync
      $error("bsh_host_ctrl: the two sync codes must differ");
   end

   bsh_state_e    state, nstate;
   logic          ld;
   logic [TW-1:0] ld_val;
   logic          tmr_zero;
   logic [2:0]    lvl;
   logic [1:0]    prv;
   logic          sen_lvl, sen_fall, sck_rise, sin_s;
   logic          shift_last, shift_clr, shift_en, done;
   logic          tx_mode, first_q;

   // ---------------- input synchronisation and edge detection
   bsh_insync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_insync (
      .clk (clk), .rst_n (rst_n), .din ({sen_n, sclk, sin}), .lvl (lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= 2'b11;
      else        prv <= lvl[2:1];
   end

   assign sen_lvl  = lvl[2];
   assign sen_fall = prv[1] & ~lvl[2];
   assign sck_rise = ~prv[0] & lvl[1];
   assign sin_s    = lvl[0];

   // ---------------- shared duration timer
   bsh_timer #(.W(TW), .RST_VAL(TW'(PWRUP_C - 1))) u_timer (
      .clk (clk), .rst_n (rst_n), .load (ld), .load_val (ld_val), .zero (tmr_zero));

   // ---------------- byte capture
   assign shift_clr = (nstate == ST_STROBE) && (state != ST_STROBE);
   assign shift_en  = (state == ST_SHIFT) && sck_rise;
   assign done      = shift_en && shift_last;

   bsh_shift #(.W(8), .LSB_FIRST(1'b1)) u_shift (
      .clk (clk), .rst_n (rst_n), .clr (shift_clr), .en (shift_en),
      .din (sin_s), .data (rx_byte), .last (shift_last));

   // ---------------- sequencing
   always_comb begin
      nstate = state;
      ld     = 1'b0;
      ld_val = '0;
      case (state)
         ST_PWRUP:   if (tmr_zero) begin nstate = ST_RST1; ld = 1'b1; ld_val = TW'(PH1_C - 1); end
         ST_RST1:    if (tmr_zero) begin nstate = ST_RST2; ld = 1'b1; ld_val = TW'(PH2_C - 1); end
         ST_RST2:    if (tmr_zero) begin nstate = ST_RST3; ld = 1'b1; ld_val = TW'(PH3_C - 1); end
         ST_RST3:    if (tmr_zero) nstate = ST_EN_HI;
         ST_EN_HI:   if (sen_lvl) nstate = ST_EN_FALL;
         ST_EN_FALL: if (sen_fall) begin nstate = ST_STROBE; ld = 1'b1; ld_val = TW'(STROBE_C - 1); end
         ST_IDLE: begin
            if (tx_req) nstate = ST_TX_ARM;
            else if (sen_fall) begin nstate = ST_STROBE; ld = 1'b1; ld_val = TW'(STROBE_C - 1); end
         end
         ST_TX_ARM:  if (!sen_lvl) begin nstate = ST_STROBE; ld = 1'b1; ld_val = TW'(STROBE_C - 1); end
         ST_STROBE:  if (tmr_zero) begin nstate = ST_SHIFT; ld = 1'b1; ld_val = TW'(TO_C - 1); end
         ST_SHIFT: begin
            if (sck_rise) begin
               if (shift_last) nstate = ST_HOLD;
               else begin ld = 1'b1; ld_val = TW'(TO_C - 1); end
            end else if (tmr_zero) begin
               nstate = ST_IDLE;
            end
         end
         ST_HOLD: begin
            if (end_xfer) nstate = ST_IDLE;
            else if (next_byte) begin nstate = ST_STROBE; ld = 1'b1; ld_val = TW'(STROBE_C - 1); end
         end
         default:    nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_PWRUP;
         tx_mode    <= 1'b0;
         first_q    <= 1'b0;
         link_up    <= 1'b0;
         rx_valid   <= 1'b0;
         rx_is_sync <= 1'b0;
         timeout    <= 1'b0;
      end else begin
         state <= nstate;
         if (nstate == ST_TX_ARM)   tx_mode <= 1'b1;
         else if (nstate == ST_IDLE) tx_mode <= 1'b0;
         if (shift_clr) first_q <= (state != ST_HOLD);
         if (state == ST_EN_FALL && nstate == ST_STROBE) link_up <= 1'b1;
         rx_valid   <= done;
         rx_is_sync <= done && first_q;
         timeout    <= (state == ST_SHIFT) && !sck_rise && tmr_zero;
      end
   end

   assign msg_rdy = (state == ST_RST1) || (state == ST_RST2) || tx_mode;
   assign srdy_n  = !((state == ST_RST2) || (state == ST_RST3) || (state == ST_STROBE));

   always_comb begin
      sync_kind = SK_NONE;
      if (rx_valid && rx_is_sync) begin
         if (rx_byte == SYNC_DEV)       sync_kind = SK_DEV_MSG;
         else if (rx_byte == SYNC_HOST) sync_kind = SK_HOST_GO;
         else                           sync_kind = SK_UNKNOWN;
      end
   end

   // ---------------- checks next to the sequencer
   logic [TW:0] strobe_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  strobe_len <= '0;
      else if (state == ST_STROBE) strobe_len <= strobe_len + 1'b1;
      else                         strobe_len <= '0;
   end

   a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EN_HI && $past(state) != ST_EN_HI) |-> ($past(state) == ST_RST3 && $past(tmr_zero)));

   a_r5_first_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STROBE && $past(state) == ST_EN_FALL) |-> $past(sen_fall));

   a_r6_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && $past(state) == ST_STROBE) |-> (strobe_len == (TW+1)'(STROBE_C)));

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r10_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STROBE && $past(state) == ST_TX_ARM) |-> (msg_rdy && !$past(sen_lvl)));

   a_r12_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (state == ST_IDLE && !msg_rdy && !rx_valid));

endmodule

// File: tb/bsh_host_ctrl_bench.sv
module bsh_host_ctrl_bench;

   localparam int unsigned KHZ    = 20;
   localparam int unsigned TO_CYC = 40;
   localparam logic [7:0]  S_DEV  = 8'hA5;
   localparam logic [7:0]  S_HOST = 8'hA4;

   // expected counts derived from the requirement formulas
   function automatic int cyc_us(input int unsigned us);
      return (KHZ * us) / 1000;
   endfunction
   localparam int E_PWR = (KHZ * 1000) / 1000;
   localparam int E_P1  = (KHZ * 1000) / 1000;
   localparam int E_P2  = (KHZ * 300) / 1000;
   localparam int E_P3  = (KHZ * 1000) / 1000;
   localparam int E_STB = (KHZ * 250_000 + 999_999) / 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_req = 1'b0, next_byte = 1'b0, end_xfer = 1'b0;
   logic       sen_n = 1'b0, sclk = 1'b1, sin = 1'b1;
   logic       msg_rdy, srdy_n, link_up, rx_valid, rx_is_sync, timeout;
   logic [7:0] rx_byte;
   logic [1:0] sync_kind;

   always #2 clk = ~clk;

   bsh_host_ctrl #(
      .CLK_KHZ(KHZ), .PWRUP_US(1000), .PH1_US(1000), .PH2_US(300), .PH3_US(1000),
      .STROBE_NS(250_000), .TIMEOUT_CYC(TO_CYC), .SYNC_STAGES(2),
      .SYNC_DEV(S_DEV), .SYNC_HOST(S_HOST)
   ) u_bsh_host_ctrl (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .next_byte(next_byte), .end_xfer(end_xfer),
      .sen_n(sen_n), .sclk(sclk), .sin(sin), .msg_rdy(msg_rdy), .srdy_n(srdy_n),
      .link_up(link_up), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_is_sync(rx_is_sync),
      .sync_kind(sync_kind), .timeout(timeout));

   int errors = 0, checks = 0;
   bit finished = 1'b0;

   int         vcnt = 0, tcnt = 0, scnt = 0;
   logic [7:0] last_byte;
   logic       last_sync;
   logic [1:0] last_kind;
   logic       prev_srdy = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            vcnt++;
            last_byte = rx_byte;
            last_sync = rx_is_sync;
            last_kind = sync_kind;
         end
         if (timeout) tcnt++;
         if (prev_srdy && !srdy_n) scnt++;
         prev_srdy = srdy_n;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_kind(input logic [7:0] b, input bit first);
      if (!first)      return 2'b00;
      if (b == S_DEV)  return 2'b01;
      if (b == S_HOST) return 2'b10;
      return 2'b11;
   endfunction

   task automatic measure(input logic em, input logic es, output int n);
      n = 0;
      while (msg_rdy === em && srdy_n === es && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic recv_byte(input logic [7:0] b, input bit first, input logic exp_msg);
      int w = 0;
      int n = 0;
      int v0;
      while (srdy_n !== 1'b0 && w < 60) begin w++; @(negedge clk); end
      chk(srdy_n === 1'b0, "R6", "strobe started", int'(srdy_n), 0);
      chk(msg_rdy === exp_msg, first ? "R11/R10" : "R9", "msg_rdy in strobe", int'(msg_rdy), int'(exp_msg));
      while (srdy_n === 1'b0 && n < 100) begin n++; @(negedge clk); end
      chk(n == E_STB, "R6", "strobe low cycles", n, E_STB);
      v0 = vcnt;
      for (int i = 0; i < 8; i++) begin
         sclk = 1'b0; sin = b[i];
         repeat (3) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      chk(vcnt == v0 + 1, "R7", "single rx_valid", vcnt - v0, 1);
      chk(last_byte == b, "R7", "byte value lsb first", int'(last_byte), int'(b));
      chk(last_sync == first, "R8", "sync flag", int'(last_sync), int'(first));
      chk(last_kind == exp_kind(b, first), "R8", "sync kind", int'(last_kind), int'(exp_kind(b, first)));
   endtask

   task automatic close_xfer;
      end_xfer = 1'b1; @(negedge clk); end_xfer = 1'b0;
      repeat (3) @(negedge clk);
      chk(msg_rdy === 1'b0 && srdy_n === 1'b1, "R9", "idle after end_xfer", int'({msg_rdy, srdy_n}), 1);
   endtask

   task automatic ask_next(input logic [7:0] b, input logic exp_msg);
      next_byte = 1'b1; @(negedge clk); next_byte = 1'b0;
      recv_byte(b, 1'b0, exp_msg);
   endtask

   task automatic dev_open;
      sen_n = 1'b1; repeat (5) @(negedge clk); sen_n = 1'b0;
   endtask

   task automatic tx_open;
      int s0;
      sen_n = 1'b1; repeat (5) @(negedge clk);
      s0 = scnt;
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
      repeat (12) @(negedge clk);
      chk(msg_rdy === 1'b1, "R10", "msg_rdy before strobe", int'(msg_rdy), 1);
      chk(scnt == s0, "R10", "no strobe while enable high", scnt - s0, 0);
      sen_n = 1'b0;
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
   end

   initial begin
      int n, s0, v0, t0;
      logic [7:0] b;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 state at release
      chk(msg_rdy === 1'b0 && srdy_n === 1'b1, "R1", "outputs after reset", int'({msg_rdy, srdy_n}), 1);
      chk(link_up === 1'b0 && rx_valid === 1'b0 && timeout === 1'b0, "R1", "flags after reset",
          int'({link_up, rx_valid, timeout}), 0);
      measure(1'b0, 1'b1, n); chk(n == E_PWR, "R1", "power-up wait", n, E_PWR);
      measure(1'b1, 1'b1, n); chk(n == E_P1, "R2", "phase one length", n, E_P1);
      measure(1'b1, 1'b0, n); chk(n == E_P2, "R3", "phase two length", n, cyc_us(300));
      measure(1'b0, 1'b0, n); chk(n == E_P3, "R4", "phase three length", n, E_P3);
      chk(msg_rdy === 1'b0 && srdy_n === 1'b1, "R4", "ready back high", int'({msg_rdy, srdy_n}), 1);

      // R5 enable must rise then fall
      s0 = scnt;
      repeat (30) @(negedge clk);
      chk(scnt == s0 && link_up === 1'b0, "R5", "no strobe with enable held low", scnt - s0, 0);
      sen_n = 1'b1; repeat (10) @(negedge clk);
      chk(scnt == s0, "R5", "no strobe on rise", scnt - s0, 0);
      sen_n = 1'b0;
      recv_byte(S_HOST, 1'b1, 1'b0);
      chk(link_up === 1'b1, "R5", "link_up after first strobe", int'(link_up), 1);
      close_xfer();

      // R11 device-initiated receive, several bytes
      dev_open();
      recv_byte(S_DEV, 1'b1, 1'b0);
      ask_next(8'h01, 1'b0);
      ask_next(8'h80, 1'b0);
      ask_next(8'h5A, 1'b0);
      close_xfer();

      // R10 transmit mode, then R9 priority of end_xfer
      tx_open();
      recv_byte(S_HOST, 1'b1, 1'b1);
      s0 = scnt;
      next_byte = 1'b1; end_xfer = 1'b1; @(negedge clk);
      next_byte = 1'b0; end_xfer = 1'b0;
      repeat (12) @(negedge clk);
      chk(scnt == s0 && msg_rdy === 1'b0, "R9", "end_xfer beats next_byte", scnt - s0, 0);

      // R8 unknown sync value
      dev_open();
      recv_byte(8'h3C, 1'b1, 1'b0);
      close_xfer();

      // R13 stray clocks in idle
      v0 = vcnt; s0 = scnt;
      for (int i = 0; i < 10; i++) begin
         sclk = 1'b0; sin = 1'(i); repeat (3) @(negedge clk);
         sclk = 1'b1; repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk(vcnt == v0 && scnt == s0, "R13", "idle clocks ignored", vcnt - v0, 0);
      dev_open();
      recv_byte(S_DEV, 1'b1, 1'b0);
      close_xfer();

      // R12 gap timeout, partial byte, in transmit mode
      tx_open();
      while (srdy_n !== 1'b0) @(negedge clk);
      while (srdy_n !== 1'b1) @(negedge clk);
      t0 = tcnt; v0 = vcnt;
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b0; sin = 1'b1; repeat (3) @(negedge clk);
         sclk = 1'b1; repeat (3) @(negedge clk);
      end
      repeat (30) @(negedge clk);
      chk(tcnt == t0, "R12", "no early timeout", tcnt - t0, 0);
      repeat (30) @(negedge clk);
      chk(tcnt == t0 + 1, "R12", "timeout pulse", tcnt - t0, 1);
      chk(vcnt == v0 && msg_rdy === 1'b0 && srdy_n === 1'b1, "R12", "idle after timeout",
          int'({msg_rdy, srdy_n}), 1);

      // constrained random exchanges
      for (int k = 0; k < 12; k++) begin
         bit dir = 1'($urandom % 2);
         int nb  = 1 + int'($urandom % 3);
         int sel = int'($urandom % 3);
         b = (sel == 0) ? S_DEV : (sel == 1) ? S_HOST : 8'($urandom);
         if (sel == 2 && (b == S_DEV || b == S_HOST)) b = 8'h00;
         if (dir) tx_open(); else dev_open();
         recv_byte(b, 1'b1, dir);
         for (int j = 1; j < nb; j++) ask_next(8'($urandom), dir);
         close_xfer();
      end

      report();
   end

endmodule